// File: doc/BRIEF.md
# Burst Memory Initial-Latency Sequencer

This block sits on the controller side of a synchronous burst pseudo-static RAM whose address and data share one bus. When a burst request is accepted, the sequencer marks the address phase with a one-cycle strobe. It takes the initial latency from a configuration word and counts the clocks from that address cycle. It then raises a one-cycle data-valid strobe for each beat of the burst and pulses a done flag after the last beat.

The configuration word carries a three-bit latency code and a mode bit. In variable mode the memory's WAIT signal stretches the access: a beat is taken only in a cycle where WAIT is low. This covers a refresh collision during the latency phase and stalls in the middle of a burst. In fixed mode the sequencer always allows for a refresh collision by waiting twice the coded latency, and it never looks at WAIT. A reserved latency code falls back to the reset-default code and sets a sticky error flag.

Top module: `burst_latency_seq`

## Requirements
- R1: The latency code sits in cfg_word[13:11]. Code 3'b010 gives latency 2, 3'b011 gives latency 3 and 3'b100 gives latency 4. In variable mode with WAIT low, the first beat_valid comes L+1 cycles after the cycle in which adv_o is high.
- R2: Any other code is treated as latency 3, and cfg_err is set in the cycle after that burst is accepted. cfg_err stays high until reset.
- R3: cfg_word[14]=1 selects fixed mode, which waits double the coded latency: the first beat comes 2L+1 cycles after the address cycle. cfg_word[14]=0 selects variable mode.
- R4: In fixed mode wait_i has no effect. Beats are issued in BURST_LEN consecutive cycles whatever the level of WAIT.
- R5: In variable mode a beat is taken only in a data-phase cycle with wait_i low. WAIT held high past the latency delays the first beat, and WAIT high in mid-burst inserts a gap.
- R6: Each burst issues exactly BURST_LEN (default 4) beat_valid strobes. beat_idx counts 0 to BURST_LEN-1 across them.
- R7: burst_done is a one-cycle pulse in the cycle after the last beat.
- R8: req_ready is high only when idle. adv_o is high exactly in the cycle that accepts a request (req_valid and req_ready both high). Requests made while busy are ignored, and configuration changes made while busy do not alter the burst in progress.
- R9: After reset, req_ready=1 while adv_o, beat_valid, burst_done and cfg_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | CFG_W (16) | Configuration image, sampled when a burst is accepted |
| req_valid | input | 1 | Burst request |
| req_ready | output | 1 | High when idle and able to accept a request |
| adv_o | output | 1 | Address-phase strobe; marks the accepted cycle |
| wait_i | input | 1 | Active-high WAIT from memory, same edge as data |
| beat_valid | output | 1 | Data beat transferred this cycle |
| beat_idx | output | IDX_W (2) | Index of the current beat |
| burst_done | output | 1 | One-cycle pulse after the last beat |
| cfg_err | output | 1 | Sticky flag: a reserved latency code was used |

## Verification
A bad latency count or decode shows up at the first beat_valid, which arrives early or late by whole cycles. This is seen within nine cycles of adv_o, and burst_done then shifts by the same amount. A bad beat counter shows up as the wrong number of strobes, as beat_idx out of sequence, or as a done pulse that comes at the wrong time or never comes, all within the burst. A stuck mode or error register is caught either by WAIT gaps that should not be there or by a cfg_err value that is wrong right after the accepting burst.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LAT_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA, ST_DONE} seq_state_t;

  function automatic logic code_reserved(input logic [2:0] code);
    return !(code == 3'd2 || code == 3'd3 || code == 3'd4);
  endfunction

  function automatic logic [LAT_W-1:0] base_latency(input logic [2:0] code);
    case (code)
      3'd2:    return 4'd2;
      3'd4:    return 4'd4;
      default: return 4'd3;
    endcase
  endfunction

  function automatic logic [LAT_W-1:0] access_latency(input logic [LAT_W-1:0] base,
                                                      input logic fixed);
    return fixed ? (base << 1) : base;
  endfunction
endpackage

// File: rtl/bls_cfg_decode.sv
module bls_cfg_decode
  import bls_pkg::*;
#(
  parameter int CFG_W    = 16,
  parameter int LAT_LSB  = 11,
  parameter int MODE_BIT = 14
) (
  input  logic [CFG_W-1:0] cfg_word,
  output logic [LAT_W-1:0] lat_cycles,
  output logic             fixed_mode,
  output logic             code_bad
);
  logic [2:0] lat_code;
  logic       unused_cfg;

  assign lat_code   = cfg_word[LAT_LSB +: 3];
  assign fixed_mode = cfg_word[MODE_BIT];
  assign code_bad   = code_reserved(lat_code);
  assign lat_cycles = access_latency(base_latency(lat_code), fixed_mode);
  assign unused_cfg = ^cfg_word;
endmodule

// File: rtl/bls_lat_counter.sv
module bls_lat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (run && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire = run && (cnt_q == W'(1));

  // R1
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R3
  nonzero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));
endmodule

// File: rtl/bls_beat_tracker.sv
module bls_beat_tracker #(
  parameter int BURST_LEN = 4,
  localparam int IDX_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) idx_q <= '0;
    else if (step)       idx_q <= last ? '0 : idx_q + 1'b1;
  end

  assign idx  = idx_q;
  assign last = (idx_q == IDX_W'(BURST_LEN - 1));

  // R6
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !clear) |=> (idx_q == '0));

  // R6
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last && !clear) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/burst_latency_seq.sv
module burst_latency_seq
  import bls_pkg::*;
#(
  parameter int CFG_W     = 16,
  parameter int LAT_LSB   = 11,
  parameter int MODE_BIT  = 14,
  parameter int BURST_LEN = 4,
  localparam int IDX_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             adv_o,
  input  logic             wait_i,
  output logic             beat_valid,
  output logic [IDX_W-1:0] beat_idx,
  output logic             burst_done,
  output logic             cfg_err
);
  seq_state_t       state_q, state_d;
  logic             fixed_q, err_q;
  logic [LAT_W-1:0] dec_lat;
  logic             dec_fixed, dec_bad;
  logic             start, lat_expire, beat_take, last_beat, in_lat, in_data;

  bls_cfg_decode #(.CFG_W(CFG_W), .LAT_LSB(LAT_LSB), .MODE_BIT(MODE_BIT)) u_dec (
    .cfg_word  (cfg_word),
    .lat_cycles(dec_lat),
    .fixed_mode(dec_fixed),
    .code_bad  (dec_bad)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign start     = req_valid && req_ready;
  assign in_lat    = (state_q == ST_LAT);
  assign in_data   = (state_q == ST_DATA);
  assign beat_take = in_data && (fixed_q || !wait_i);

  bls_lat_counter #(.W(LAT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .load_val(dec_lat),
    .run     (in_lat),
    .expire  (lat_expire)
  );

  bls_beat_tracker #(.BURST_LEN(BURST_LEN)) u_beat (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(start),
    .step (beat_take),
    .idx  (beat_idx),
    .last (last_beat)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start)                  state_d = ST_LAT;
      ST_LAT:  if (lat_expire)             state_d = ST_DATA;
      ST_DATA: if (beat_take && last_beat) state_d = ST_DONE;
      default:                             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fixed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) begin
        fixed_q <= dec_fixed;
        err_q   <= err_q | dec_bad;
      end
    end
  end

  assign adv_o      = start;
  assign beat_valid = beat_take;
  assign burst_done = (state_q == ST_DONE);
  assign cfg_err    = err_q;

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> !req_ready);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && last_beat) |=> burst_done);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> (!burst_done && req_ready));

  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R2
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(adv_o));
endmodule

// File: tb/burst_latency_seq_tb.sv
`timescale 1ns/1ps
module burst_latency_seq_tb;
  localparam int BL = 4;

  typedef struct packed {
    logic [2:0] code;
    logic       fx;
    logic [4:0] ws;
    logic [4:0] we;
    logic [4:0] first;
    logic [4:0] done;
    logic       err;
  } vec_t;

  // code, fixed, wait start, wait end, first beat cycle, done cycle, cfg_err after
  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{3'd3, 1'b0, 5'd0, 5'd0,  5'd4, 5'd8,  1'b0},  // R1 default code
    '{3'd2, 1'b0, 5'd0, 5'd0,  5'd3, 5'd7,  1'b0},  // R1
    '{3'd4, 1'b0, 5'd0, 5'd0,  5'd5, 5'd9,  1'b0},  // R1
    '{3'd2, 1'b1, 5'd0, 5'd0,  5'd5, 5'd9,  1'b0},  // R3
    '{3'd3, 1'b1, 5'd1, 5'd12, 5'd7, 5'd11, 1'b0},  // R4 WAIT ignored
    '{3'd4, 1'b1, 5'd0, 5'd0,  5'd9, 5'd13, 1'b0},  // R3
    '{3'd3, 1'b0, 5'd1, 5'd6,  5'd7, 5'd11, 1'b0},  // R5 collision stretch
    '{3'd2, 1'b0, 5'd1, 5'd2,  5'd3, 5'd7,  1'b0},  // R5 WAIT gone in time
    '{3'd2, 1'b0, 5'd4, 5'd4,  5'd3, 5'd8,  1'b0},  // R5 mid-burst gap
    '{3'd7, 1'b0, 5'd0, 5'd0,  5'd4, 5'd8,  1'b1},  // R2 reserved
    '{3'd0, 1'b1, 5'd0, 5'd0,  5'd7, 5'd11, 1'b1}   // R2 reserved, fixed
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_word;
  logic        req_valid, wait_i;
  logic        req_ready, adv_o, beat_valid, burst_done, cfg_err;
  logic [1:0]  beat_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  burst_latency_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .req_valid(req_valid),
    .req_ready(req_ready), .adv_o(adv_o), .wait_i(wait_i),
    .beat_valid(beat_valid), .beat_idx(beat_idx), .burst_done(burst_done),
    .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cfg(input logic [2:0] code, input logic fx);
    logic [15:0] w;
    w = 16'h8405;
    w[13:11] = code;
    w[14] = fx;
    return w;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; wait_i = 1'b0; cfg_word = mk_cfg(3'd3, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    int first, done, beats;
    bit idx_ok;
    first = -1; done = -1; beats = 0; idx_ok = 1'b1;
    @(negedge clk);
    cfg_word = mk_cfg(v.code, v.fx);
    req_valid = 1'b1;
    wait_i = 1'b0;
    #1;
    chk(adv_o && req_ready, "R8", {tag, " accept strobe"}, adv_o, 1);
    for (int k = 1; k < 40 && done < 0; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      cfg_word = 16'hFFFF;
      wait_i = (k >= int'(v.ws) && k <= int'(v.we) && v.ws != 0);
      #1;
      if (beat_valid) begin
        if (first < 0) first = k;
        if (int'(beat_idx) != beats) idx_ok = 1'b0;
        beats++;
      end
      if (burst_done) done = k;
    end
    chk(first == int'(v.first), v.fx ? "R3" : "R1", {tag, " first beat"}, first, v.first);
    chk(beats == BL, "R6", {tag, " beat count"}, beats, BL);
    chk(idx_ok, "R6", {tag, " beat index order"}, idx_ok, 1);
    chk(done == int'(v.done), "R7", {tag, " done cycle"}, done, v.done);
    @(negedge clk);
    #1;
    chk(!burst_done && req_ready, "R7", {tag, " done single pulse"}, burst_done, 0);
    chk(cfg_err == v.err, "R2", {tag, " cfg_err"}, cfg_err, v.err);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; wait_i = 1'b0; cfg_word = '0;
    do_reset();
    // R9 reset state
    chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
    chk(!beat_valid && !burst_done && !adv_o, "R9", "strobes after reset",
        {beat_valid, burst_done, adv_o}, 0);
    chk(cfg_err == 1'b0, "R9", "cfg_err after reset", cfg_err, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], $sformatf("vec%0d", i));

    // R2 reset clears the sticky flag
    do_reset();
    chk(cfg_err == 1'b0, "R2", "cfg_err cleared by reset", cfg_err, 0);

    // R8 requests while busy are ignored; held request accepted once idle
    begin
      int done_n, second_first, second_done;
      bit busy_ok;
      done_n = 0; second_first = -1; second_done = -1; busy_ok = 1'b1;
      @(negedge clk);
      cfg_word = mk_cfg(3'd2, 1'b0);
      req_valid = 1'b1;
      wait_i = 1'b0;
      #1;
      chk(adv_o, "R8", "holdoff first accept", adv_o, 1);
      for (int k = 1; k < 30; k++) begin
        @(negedge clk);
        req_valid = (k <= 8);
        cfg_word = mk_cfg(3'd4, 1'b0);
        #1;
        if (k <= 7 && (adv_o || req_ready)) busy_ok = 1'b0;
        if (k == 8) chk(adv_o && req_ready, "R8", "held request accepted at idle", adv_o, 1);
        if (beat_valid && k > 8 && second_first < 0) second_first = k;
        if (burst_done) begin
          done_n++;
          if (done_n == 1) chk(k == 7, "R8", "busy cfg change ignored, done", k, 7);
          if (done_n == 2) second_done = k;
        end
      end
      chk(busy_ok, "R8", "no accept while busy", busy_ok, 1);
      chk(second_first == 13, "R1", "second burst first beat", second_first, 13);
      chk(second_done == 17, "R7", "second burst done", second_done, 17);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule